// File: doc/BRIEF.md
# Fractional Scanline and Frame Timing Generator

This block turns the system clock into the line and frame rhythm of a video raster for either of two video standards. The line period is kept in a 20.12 fixed-point accumulator. At each line boundary only the fractional bits are kept, and the increment of the active standard is added to them. The integer part of the result is the length of the next line in clocks. The average line period is therefore a fractional number of clocks: about 2146.31 at 60 Hz and about 2164.14 at 50 Hz. Short-term jitter stays within one clock, and there is no long-term drift.

The line boundary strobe drives a line counter. From that counter the block derives a vertical-blank interrupt pulse, a frame-wrap strobe, a frame counter, an odd/even field bit used in interlaced operation, and an audio-update tick that repeats every fixed number of lines. Other blocks use the line strobe as a clock-enable, for example a timer channel that counts scanlines.

Top module: `scan_timing_gen`

## Requirements
- R1: `hsync` is high for exactly one clock, on the last clock of each line. Each line lasts the integer part, in clocks, of that line's accumulator value.
- R2: The first line after reset uses the increment of the sampled standard as its accumulator value. Each later line uses the fraction (low 12 bits) kept from the previous line plus the current standard's increment. The default increments are 8791293 for `std_sel`=0 (60 Hz) and 8864320 for `std_sel`=1 (50 Hz). For example, an increment of 5.25 clocks gives the repeating lengths 5,5,5,6.
- R3: Line numbers run from 0 to total−1. The defaults are 263 lines when `std_sel`=0 and 313 lines when it is 1. On the hsync that ends the last line, `frame_wrap` pulses, the line number returns to 0 and `frame_count` increments.
- R4: `vblank_irq` pulses together with the hsync that makes the line number equal to the vblank line (default 240). It never coincides with `frame_wrap`.
- R5: `field_odd` goes to 0 on the vblank pulse. On each frame wrap it takes `interlace_en` AND bit 0 of the new `frame_count`. Otherwise it holds its value.
- R6: `audio_tick` pulses together with every 32nd hsync (default), counted without break across frames from reset.
- R7: `std_sel` is sampled only during reset and at frame wrap. A change in mid-frame leaves that frame's line lengths and line total unchanged. The first line of the next frame adds the new increment to the carried fraction.
- R8: After reset `frame_count` is 0, `field_odd` is 0, and no pulse output is high while the first line runs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| std_sel | input | 1 | Standard select: 0 = 60 Hz, 1 = 50 Hz |
| interlace_en | input | 1 | Lets the frame parity reach `field_odd` |
| hsync | output | 1 | One-clock strobe on the last clock of each line |
| vblank_irq | output | 1 | One-clock vertical-blank interrupt pulse |
| frame_wrap | output | 1 | One-clock strobe when the line count wraps |
| field_odd | output | 1 | Odd/even field status bit |
| audio_tick | output | 1 | One-clock audio-update tick |
| frame_count | output | FRAME_W | Frames completed since reset |

## Verification
The bench runs the block with a small increment of 5.25 and 6.5 clocks and short frames, and measures every line length. A design that drops the carried fraction would produce only 5-clock lines, and a design that truncates at the wrong point would shift where the 6-clock lines fall. The standard is switched in mid-frame. A design that samples it at once would change line lengths inside that frame, and one that resets the fraction at the switch would make the first new line 6 clocks long instead of 7. The audio tick is followed across frame boundaries to catch a counter that restarts at each wrap. The field bit is checked with interlace on and off, on an odd frame, to catch parity leaking through when interlace is disabled.

// File: rtl/scan_timing_pkg.sv
package scan_timing_pkg;

    localparam int FRAC_W = 12;
    localparam int ACC_W  = 32;
    localparam int INT_W  = ACC_W - FRAC_W;

    typedef enum logic {
        STD_60HZ = 1'b0,
        STD_50HZ = 1'b1
    } vid_std_e;

    typedef struct packed {
        logic hsync;
        logic vblank;
        logic wrap;
        logic tick;
    } line_evt_t;

    function automatic logic [ACC_W-1:0] pick_inc(
        input vid_std_e         s,
        input logic [ACC_W-1:0] inc60,
        input logic [ACC_W-1:0] inc50
    );
        return (s == STD_50HZ) ? inc50 : inc60;
    endfunction

endpackage

// File: rtl/sct_line_accum.sv
module sct_line_accum
    import scan_timing_pkg::*;
#(
    parameter logic [ACC_W-1:0] INC_60 = 32'd8791293,
    parameter logic [ACC_W-1:0] INC_50 = 32'd8864320
) (
    input  logic     clk,
    input  logic     rst,
    input  vid_std_e std_next,
    output logic     hsync
);
    localparam int LEN_60  = int'(INC_60 >> FRAC_W);
    localparam int LEN_50  = int'(INC_50 >> FRAC_W);
    localparam int MIN_LEN = (LEN_60 < LEN_50) ? LEN_60 : LEN_50;
    localparam int MAX_LEN = (LEN_60 < LEN_50) ? LEN_50 : LEN_60;

    logic [ACC_W-1:0] acc;
    logic [INT_W-1:0] clk_cnt;
    logic [INT_W-1:0] line_len;
    logic [ACC_W-1:0] inc_sel;

    assign line_len = acc[ACC_W-1:FRAC_W];
    assign inc_sel  = pick_inc(std_next, INC_60, INC_50);
    assign hsync    = (clk_cnt == line_len - INT_W'(1));

    always_ff @(posedge clk) begin
        if (rst) begin
            acc     <= inc_sel;
            clk_cnt <= '0;
        end else if (hsync) begin
            acc     <= {{INT_W{1'b0}}, acc[FRAC_W-1:0]} + inc_sel;
            clk_cnt <= '0;
        end else begin
            clk_cnt <= clk_cnt + INT_W'(1);
        end
    end

    // R2: with the fraction carried, a line is never more than one clock longer than the integer increment
    p_len_range_r2: assert property (@(posedge clk) disable iff (rst)
        (line_len >= INT_W'(MIN_LEN)) && (line_len <= INT_W'(MAX_LEN + 1)));

    // R1: the clock count restarts after each line strobe
    p_restart_r1: assert property (@(posedge clk) disable iff (rst)
        hsync |=> (clk_cnt == '0));

    // R1: the count never runs past the end of the line
    p_cnt_bound_r1: assert property (@(posedge clk) disable iff (rst)
        clk_cnt < line_len);
endmodule

// File: rtl/sct_line_seq.sv
module sct_line_seq
    import scan_timing_pkg::*;
#(
    parameter int LINES_60 = 263,
    parameter int LINES_50 = 313,
    parameter int VBL_LINE = 240,
    parameter int LINE_W   = 9,
    parameter int FRAME_W  = 16
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               hsync,
    input  logic               std_sel,
    input  logic               interlace_en,
    output vid_std_e           std_next,
    output logic               vblank_irq,
    output logic               frame_wrap,
    output logic               field_odd,
    output logic [FRAME_W-1:0] frame_count
);
    vid_std_e           std_q;
    logic [LINE_W-1:0]  line;
    logic [LINE_W-1:0]  line_inc;
    logic [LINE_W-1:0]  total;
    logic               last;
    logic [FRAME_W-1:0] frame_inc;

    assign total      = (std_q == STD_50HZ) ? LINE_W'(LINES_50) : LINE_W'(LINES_60);
    assign line_inc   = line + LINE_W'(1);
    assign last       = (line_inc == total);
    assign frame_inc  = frame_count + FRAME_W'(1);
    assign frame_wrap = hsync && last;
    assign vblank_irq = hsync && !last && (line_inc == LINE_W'(VBL_LINE));
    assign std_next   = (rst || frame_wrap) ? vid_std_e'(std_sel) : std_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            std_q       <= vid_std_e'(std_sel);
            line        <= '0;
            frame_count <= '0;
            field_odd   <= 1'b0;
        end else if (hsync) begin
            if (last) begin
                line        <= '0;
                frame_count <= frame_inc;
                std_q       <= vid_std_e'(std_sel);
                field_odd   <= interlace_en & frame_inc[0];
            end else begin
                line <= line_inc;
                if (vblank_irq) field_odd <= 1'b0;
            end
        end
    end

    // R3: wrap returns the line number to zero and advances the frame count
    p_wrap_r3: assert property (@(posedge clk) disable iff (rst)
        frame_wrap |=> (line == '0) && (frame_count == $past(frame_count) + FRAME_W'(1)));

    // R3: the line number stays below the frame total
    p_line_bound_r3: assert property (@(posedge clk) disable iff (rst)
        line < total);

    // R4, R5: the vblank pulse lands on the vblank line and clears the field bit
    p_vblank_r4: assert property (@(posedge clk) disable iff (rst)
        vblank_irq |=> (line == LINE_W'(VBL_LINE)) && !field_odd);

    // R4: vblank and wrap never coincide
    p_excl_r4: assert property (@(posedge clk) disable iff (rst)
        $onehot0({vblank_irq, frame_wrap}));

    // R7: the standard only changes across a wrap
    p_std_hold_r7: assert property (@(posedge clk) disable iff (rst)
        !frame_wrap |=> $stable(std_q));

    // R5: the field bit moves only on a vblank pulse or a wrap
    p_field_hold_r5: assert property (@(posedge clk) disable iff (rst)
        !(vblank_irq || frame_wrap) |=> $stable(field_odd));
endmodule

// File: rtl/sct_audio_tick.sv
module sct_audio_tick #(
    parameter int AUDIO_LINES = 32
) (
    input  logic clk,
    input  logic rst,
    input  logic hsync,
    output logic tick
);
    localparam int AUD_W = $clog2(AUDIO_LINES + 1);

    logic [AUD_W-1:0] cnt;

    assign tick = hsync && (cnt == AUD_W'(AUDIO_LINES - 1));

    always_ff @(posedge clk) begin
        if (rst)        cnt <= '0;
        else if (hsync) cnt <= tick ? '0 : cnt + AUD_W'(1);
    end

    // R6: a tick only comes with a line strobe
    p_tick_hsync_r6: assert property (@(posedge clk) disable iff (rst)
        tick |-> hsync);

    // R6: the line count between ticks stays in range
    p_cnt_bound_r6: assert property (@(posedge clk) disable iff (rst)
        cnt < AUD_W'(AUDIO_LINES));
endmodule

// File: rtl/scan_timing_gen.sv
module scan_timing_gen
    import scan_timing_pkg::*;
#(
    parameter logic [ACC_W-1:0] INC_60 = 32'd8791293,
    parameter logic [ACC_W-1:0] INC_50 = 32'd8864320,
    parameter int LINES_60    = 263,
    parameter int LINES_50    = 313,
    parameter int VBL_LINE    = 240,
    parameter int AUDIO_LINES = 32,
    parameter int FRAME_W     = 16
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               std_sel,
    input  logic               interlace_en,
    output logic               hsync,
    output logic               vblank_irq,
    output logic               frame_wrap,
    output logic               field_odd,
    output logic               audio_tick,
    output logic [FRAME_W-1:0] frame_count
);
    localparam int MAX_LINES = (LINES_60 > LINES_50) ? LINES_60 : LINES_50;
    localparam int LINE_W    = $clog2(MAX_LINES + 1);

    vid_std_e  std_next;
    line_evt_t evt;

    sct_line_accum #(
        .INC_60 (INC_60),
        .INC_50 (INC_50)
    ) u_accum (
        .clk      (clk),
        .rst      (rst),
        .std_next (std_next),
        .hsync    (evt.hsync)
    );

    sct_line_seq #(
        .LINES_60 (LINES_60),
        .LINES_50 (LINES_50),
        .VBL_LINE (VBL_LINE),
        .LINE_W   (LINE_W),
        .FRAME_W  (FRAME_W)
    ) u_seq (
        .clk          (clk),
        .rst          (rst),
        .hsync        (evt.hsync),
        .std_sel      (std_sel),
        .interlace_en (interlace_en),
        .std_next     (std_next),
        .vblank_irq   (evt.vblank),
        .frame_wrap   (evt.wrap),
        .field_odd    (field_odd),
        .frame_count  (frame_count)
    );

    sct_audio_tick #(
        .AUDIO_LINES (AUDIO_LINES)
    ) u_audio (
        .clk   (clk),
        .rst   (rst),
        .hsync (evt.hsync),
        .tick  (evt.tick)
    );

    assign hsync      = evt.hsync;
    assign vblank_irq = evt.vblank;
    assign frame_wrap = evt.wrap;
    assign audio_tick = evt.tick;
endmodule

// File: tb/test_scan_timing_gen.sv
module test_scan_timing_gen;
    localparam logic [31:0] T_INC60 = 32'd21504;   // 5.25 clocks
    localparam logic [31:0] T_INC50 = 32'd26624;   // 6.5 clocks
    localparam int T_L60 = 10;
    localparam int T_L50 = 12;
    localparam int T_VBL = 7;
    localparam int T_AUD = 4;
    localparam int T_FW  = 8;

    // first frame at 5.25 clocks per line, starting from zero fraction
    localparam int        EXP_LEN [10] = '{5, 5, 5, 6, 5, 5, 5, 6, 5, 5};
    localparam logic [9:0] EXP_VBL  = 10'b0001000000;
    localparam logic [9:0] EXP_WRAP = 10'b1000000000;
    localparam logic [9:0] EXP_TICK = 10'b0010001000;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic std_sel = 1'b0;
    logic interlace_en = 1'b0;
    logic hsync, vblank_irq, frame_wrap, field_odd, audio_tick;
    logic [T_FW-1:0] frame_count;

    int n_chk = 0;
    int n_fail = 0;

    always #10 clk = ~clk;

    scan_timing_gen #(
        .INC_60 (T_INC60), .INC_50 (T_INC50),
        .LINES_60 (T_L60), .LINES_50 (T_L50),
        .VBL_LINE (T_VBL), .AUDIO_LINES (T_AUD), .FRAME_W (T_FW)
    ) i_scan_timing_gen (
        .clk (clk), .rst (rst), .std_sel (std_sel), .interlace_en (interlace_en),
        .hsync (hsync), .vblank_irq (vblank_irq), .frame_wrap (frame_wrap),
        .field_odd (field_odd), .audio_tick (audio_tick), .frame_count (frame_count)
    );

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    // Called at the negedge where a line starts; returns its length and the flags seen with its strobe,
    // and the field bit at the start of the next line.
    task automatic measure(output int len, output bit v, output bit w, output bit t, output bit fld);
        len = 0; v = 0; w = 0; t = 0; fld = 0;
        forever begin
            len++;
            if (hsync) begin
                v = vblank_irq; w = frame_wrap; t = audio_tick;
                @(negedge clk);
                fld = field_odd;
                return;
            end
            if (len > 50) begin
                check("R1 line strobe timeout", len, 0);
                return;
            end
            @(negedge clk);
        end
    endtask

    initial begin
        int len;
        bit v, w, t, f;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R8: reset state
        check("R8 frame_count at reset", int'(frame_count), 0);
        check("R8 field_odd at reset", int'(field_odd), 0);
        check("R8 no pulses at reset", int'({hsync, vblank_irq, frame_wrap, audio_tick}), 0);
        rst = 1'b0;

        // Frame 1 from the vector table; standard and interlace change at line 2 (R7)
        for (int k = 0; k < 10; k++) begin
            if (k == 2) begin std_sel = 1'b1; interlace_en = 1'b1; end
            measure(len, v, w, t, f);
            check($sformatf("R2 R7 frame1 line %0d length", k), len, EXP_LEN[k]);
            check($sformatf("R4 frame1 line %0d vblank", k), int'(v), int'(EXP_VBL[k]));
            check($sformatf("R3 frame1 line %0d wrap", k), int'(w), int'(EXP_WRAP[k]));
            check($sformatf("R6 frame1 line %0d tick", k), int'(t), int'(EXP_TICK[k]));
        end
        check("R3 frame_count after frame 1", int'(frame_count), 1);
        check("R5 field after odd wrap, interlace on", int'(f), 1);

        // Frame 2 at 6.5 clocks with fraction .5 carried: 7,6,7,6,... over 12 lines (R7, R1)
        for (int k = 0; k < 12; k++) begin
            if (k == 8) interlace_en = 1'b0;
            measure(len, v, w, t, f);
            check($sformatf("R7 frame2 line %0d length", k), len, (k % 2 == 0) ? 7 : 6);
            check($sformatf("R4 frame2 line %0d vblank", k), int'(v), (k == 6) ? 1 : 0);
            check($sformatf("R3 frame2 line %0d wrap", k), int'(w), (k == 11) ? 1 : 0);
            check($sformatf("R6 frame2 line %0d tick", k), int'(t), (k == 1 || k == 5 || k == 9) ? 1 : 0);
            if (k == 6) check("R5 field cleared by vblank", int'(f), 0);
        end
        check("R3 frame_count after frame 2", int'(frame_count), 2);
        check("R5 field after even wrap", int'(f), 0);

        // Frame 3: same standard, interlace off; standard returns to 60 Hz mid-frame
        for (int k = 0; k < 12; k++) begin
            if (k == 4) std_sel = 1'b0;
            measure(len, v, w, t, f);
            check($sformatf("R7 frame3 line %0d length", k), len, (k % 2 == 0) ? 7 : 6);
            check($sformatf("R6 frame3 line %0d tick", k), int'(t), (k == 1 || k == 5 || k == 9) ? 1 : 0);
        end
        check("R3 frame_count after frame 3", int'(frame_count), 3);
        check("R5 field stays 0 on odd wrap with interlace off", int'(f), 0);

        // Frame 4: carried .5 plus 5.25 gives 5,6,5,5,5,6 (R2, R7)
        for (int k = 0; k < 6; k++) begin
            measure(len, v, w, t, f);
            check($sformatf("R2 frame4 line %0d length", k), len, (k == 1 || k == 5) ? 6 : 5);
        end

        // Reset in mid-run with 50 Hz selected (R8, R7, R6)
        std_sel = 1'b1;
        rst = 1'b1;
        @(negedge clk);
        @(negedge clk);
        check("R8 frame_count after second reset", int'(frame_count), 0);
        check("R8 field after second reset", int'(field_odd), 0);
        rst = 1'b0;
        for (int k = 0; k < 4; k++) begin
            measure(len, v, w, t, f);
            check($sformatf("R7 post-reset line %0d length", k), len, (k % 2 == 0) ? 6 : 7);
            check($sformatf("R6 post-reset line %0d tick", k), int'(t), (k == 3) ? 1 : 0);
        end
        finish_run();
    end

    initial begin
        #(20 * 200000);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end
endmodule